// File: doc/BRIEF.md
# Free-Running Counter with Compare and Capture

This peripheral keeps a 16-bit up-counter running from a divided version of the bus clock or from an external clock pin. Two compare registers, A and B, raise a flag when the counter reaches their value. Compare A can also restart the count from zero, which gives a periodic timebase. A capture register records the count on a chosen edge of an external pin. An overflow flag marks each wrap from 0xFFFF to zero.

Software reaches the block through four 32-bit words with byte-lane write strobes. Reads are combinational. The four flags hold until software writes a zero to them. Each flag has its own interrupt enable. When any enabled flag is set, the block raises one interrupt request and a 2-bit class code that names the winning source.

Top module: `freerun_timer`

## Requirements
- R1: After reset the counter, both compare registers, the capture register, the control word, all flags, `irq` and `vec_class` are zero.
- R2: Control bits [1:0] select the count rate. Code 0 divides the bus clock by 8, code 1 by 32 and code 2 by 128. In any window of 64, 256 or 1024 consecutive clocks respectively, the counter advances by exactly 8.
- R3: With clock code 3, the counter advances once for each rising edge of `ext_clk`.
- R4: When the counter holds the compare-A value at the moment it is due to advance, status bit 1 sets and the counter moves on to the next value.
- R5: With control bit 3 (clear-on-A) set, that same compare-A event reloads the counter with zero instead of advancing it.
- R6: Word 3 bits [15:0] read and write compare A when control bit 2 is 0, and compare B when it is 1. A compare-B event sets status bit 2.
- R7: An advance from 0xFFFF to 0x0000 sets status bit 3.
- R8: A qualified edge on `cap_in` copies the counter into word 3 bits [31:16] and sets status bit 0. Control bit 4 set means rising edge; clear means falling edge. An edge of the other polarity changes neither the flag nor the captured value. Word 3 bits [31:16] are read-only.
- R9: Status bits [3:0] are sticky. A write to word 1 with lane 0 enabled replaces each flag by the flag AND the written bit, so writing 1 keeps a flag and writing 0 clears it.
- R10: If hardware sets a flag in the same cycle that software clears it, the flag ends set.
- R11: Control bits [11:8] enable capture, compare A, compare B and overflow, in that order. `irq` is high exactly when some flag is set together with its enable.
- R12: `vec_class` is 0 with no request. Otherwise it is 1 for capture, 2 for either compare and 3 for overflow, with capture taking priority over compare and compare over overflow.
- R13: Word 2 bits [15:0] read the counter. A write to word 2 loads it, each byte lane on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word index: 0 control, 1 status, 2 counter, 3 compare/capture |
| bus_wen | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ext_clk | input | 1 | External count clock, synchronized inside |
| cap_in | input | 1 | Capture trigger pin, synchronized inside |
| irq | output | 1 | Interrupt request |
| vec_class | output | 2 | Winning source class |

## Verification
A counter that skips or repeats a value shows up in the next read of word 2. With the external clock it also shows up as a compare or overflow flag that appears one step early or late. A flag that drops without a clearing write, or a capture value that changes with no qualified edge, reaches the ports at once through `irq`, `vec_class` and word 1. The bench steps the counter one external edge at a time, so every expected count and flag is known exactly.

// File: rtl/freerun_timer.sv
module freerun_timer #(
  parameter int CNT_W    = 16,
  parameter int DIV0_LOG = 3,
  parameter int DIV1_LOG = 5,
  parameter int DIV2_LOG = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wen,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ext_clk,
  input  logic        cap_in,
  output logic        irq,
  output logic [1:0]  vec_class
);
  localparam int PRE_W = DIV2_LOG;
  localparam logic [PRE_W-1:0] M0 = PRE_W'((1 << DIV0_LOG) - 1);
  localparam logic [PRE_W-1:0] M1 = PRE_W'((1 << DIV1_LOG) - 1);
  localparam logic [PRE_W-1:0] M2 = PRE_W'((1 << DIV2_LOG) - 1);

  logic [1:0]       rate;
  logic             cmp_pick, clr_on_a, rise_sel;
  logic [3:0]       en;
  logic [3:0]       flags;
  logic [CNT_W-1:0] cnt, cmp_a, cmp_b, cap_val;
  logic [PRE_W-1:0] pre;
  logic [2:0]       ext_s, cap_s;

  logic wr_ctl, wr_st, wr_cnt, wr_cmp, cnt_load;
  logic tick, evt, hit_a, hit_b, hit_ovf, cap_hit;
  logic [15:0]      lane16;
  logic [CNT_W-1:0] lane_m;
  logic [3:0]       hw_set, kept;
  logic [3:0]       pend;

  wire unused_bits = ^{bus_wdata[31:16], bus_be[3:2], lane16};

  assign wr_ctl   = bus_wen && bus_addr == 2'd0;
  assign wr_st    = bus_wen && bus_addr == 2'd1 && bus_be[0];
  assign wr_cnt   = bus_wen && bus_addr == 2'd2;
  assign wr_cmp   = bus_wen && bus_addr == 2'd3;
  assign cnt_load = wr_cnt && (bus_be[0] || bus_be[1]);

  assign lane16 = {{8{bus_be[1]}}, {8{bus_be[0]}}};
  assign lane_m = lane16[CNT_W-1:0];

  always_comb begin
    case (rate)
      2'd0:    tick = (pre & M0) == M0;
      2'd1:    tick = (pre & M1) == M1;
      2'd2:    tick = (pre & M2) == M2;
      default: tick = ext_s[1] && !ext_s[2];
    endcase
  end

  assign evt     = tick && !cnt_load;
  assign hit_a   = evt && cnt == cmp_a;
  assign hit_b   = evt && cnt == cmp_b;
  assign hit_ovf = evt && (&cnt) && !(hit_a && clr_on_a);
  assign cap_hit = rise_sel ? (cap_s[1] && !cap_s[2]) : (!cap_s[1] && cap_s[2]);
  assign hw_set  = {hit_ovf, hit_b, hit_a, cap_hit};
  assign kept    = wr_st ? (flags & bus_wdata[3:0]) : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      ext_s <= '0;
      cap_s <= '0;
    end else begin
      pre   <= pre + 1'b1;
      ext_s <= {ext_s[1:0], ext_clk};
      cap_s <= {cap_s[1:0], cap_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate     <= '0;
      cmp_pick <= 1'b0;
      clr_on_a <= 1'b0;
      rise_sel <= 1'b0;
      en       <= '0;
    end else if (wr_ctl) begin
      if (bus_be[0]) begin
        rate     <= bus_wdata[1:0];
        cmp_pick <= bus_wdata[2];
        clr_on_a <= bus_wdata[3];
        rise_sel <= bus_wdata[4];
      end
      if (bus_be[1]) en <= bus_wdata[11:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_load) begin
      cnt <= (cnt & ~lane_m) | (bus_wdata[CNT_W-1:0] & lane_m);
    end else if (hit_a && clr_on_a) begin
      cnt <= '0;
    end else if (evt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
    end else if (wr_cmp) begin
      if (cmp_pick) cmp_b <= (cmp_b & ~lane_m) | (bus_wdata[CNT_W-1:0] & lane_m);
      else          cmp_a <= (cmp_a & ~lane_m) | (bus_wdata[CNT_W-1:0] & lane_m);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      cap_val <= '0;
    end else begin
      flags <= kept | hw_set;
      if (cap_hit) cap_val <= cnt;
    end
  end

  assign pend = flags & en;
  assign irq  = |pend;

  always_comb begin
    if (pend[0])                vec_class = 2'd1;
    else if (pend[1] || pend[2]) vec_class = 2'd2;
    else if (pend[3])           vec_class = 2'd3;
    else                        vec_class = 2'd0;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {20'b0, en, 3'b0, rise_sel, clr_on_a, cmp_pick, rate};
      2'd1:    bus_rdata = {28'b0, flags};
      2'd2:    bus_rdata = 32'(cnt);
      default: bus_rdata = {16'(cap_val), 16'(cmp_pick ? cmp_b : cmp_a)};
    endcase
  end
endmodule

// File: rtl/freerun_timer_chk.sv
module freerun_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wen,
  input logic [3:0]       bus_be,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       flags,
  input logic [CNT_W-1:0] cap_val,
  input logic             irq,
  input logic [1:0]       vec_class
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(bus_wen && bus_addr == 2'd2 && (bus_be[0] || bus_be[1]))
    |-> (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) != 4'd0) |-> $past(bus_wen && bus_addr == 2'd1 && bus_be[0])); // R9

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> cnt == '0); // R7

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_val != $past(cap_val)) |-> flags[0]); // R8

  AST_IRQ_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> vec_class != 2'd0); // R12

  AST_IDLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> vec_class == 2'd0); // R11
endmodule

bind freerun_timer freerun_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_be(bus_be),
  .cnt(cnt), .flags(flags), .cap_val(cap_val), .irq(irq), .vec_class(vec_class)
);

// File: tb/tb_freerun_timer.sv
`timescale 1ns/1ps
module tb_freerun_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_clk = 1'b0;
  logic        cap_in = 1'b0;
  logic        irq;
  logic [1:0]  vec_class;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  freerun_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .cap_in(cap_in),
    .irq(irq), .vec_class(vec_class)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_cap(input logic v);
    @(negedge clk) cap_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset word", d, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 0);
    check("R1 reset class", {30'b0, vec_class}, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] c0, c1;
    int win[3] = '{64, 256, 1024};
    for (int code = 0; code < 3; code++) begin
      wr(2'd0, 4'b0001, 32'(code));
      rd(2'd2, c0);
      repeat (win[code]) @(negedge clk);
      #1 c1 = bus_rdata;
      check($sformatf("R2 rate code %0d", code), c1 - c0, 32'd8);
    end
  endtask

  task automatic t_ext_and_load;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'h3);
    wr(2'd2, 4'b0011, 32'h0100);
    rd(2'd2, d);
    check("R13 counter load", d, 32'h0100);
    step(5);
    rd(2'd2, d);
    check("R3 external edges", d, 32'h0105);
    wr(2'd2, 4'b0001, 32'hFFFF_EEAB);
    rd(2'd2, d);
    check("R13 low lane only", d, 32'h01AB);
  endtask

  task automatic t_cmp_a;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'h3);
    wr(2'd3, 4'b0011, 32'h0012);
    wr(2'd1, 4'b0001, 32'h0);
    wr(2'd2, 4'b0011, 32'h0010);
    step(2);
    rd(2'd1, d);
    check("R4 no early match", d, 32'h0);
    step(1);
    rd(2'd1, d);
    check("R4 match flag", d, 32'h2);
    rd(2'd2, d);
    check("R4 counter continues", d, 32'h0013);
  endtask

  task automatic t_clear_a;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'hB);
    wr(2'd1, 4'b0001, 32'h0);
    wr(2'd2, 4'b0011, 32'h0010);
    step(3);
    rd(2'd2, d);
    check("R5 reload zero", d, 32'h0);
    rd(2'd1, d);
    check("R5 flag with reload", d, 32'h2);
  endtask

  task automatic t_cmp_b;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'h7);
    wr(2'd3, 4'b0011, 32'h0020);
    rd(2'd3, d);
    check("R6 read B", d[15:0], 16'h0020);
    wr(2'd0, 4'b0001, 32'h3);
    rd(2'd3, d);
    check("R6 A kept", d[15:0], 16'h0012);
    wr(2'd0, 4'b0001, 32'h7);
    wr(2'd1, 4'b0001, 32'h0);
    wr(2'd2, 4'b0011, 32'h001F);
    step(1);
    rd(2'd1, d);
    check("R6 no early B", d, 32'h0);
    step(1);
    rd(2'd1, d);
    check("R6 B flag", d, 32'h4);
  endtask

  task automatic t_ovf;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'h3);
    wr(2'd1, 4'b0001, 32'h0);
    wr(2'd2, 4'b0011, 32'hFFFF);
    step(1);
    rd(2'd2, d);
    check("R7 wrap value", d, 32'h0);
    rd(2'd1, d);
    check("R7 overflow flag", d, 32'h8);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'h13);
    wr(2'd2, 4'b0011, 32'h0055);
    wr(2'd1, 4'b0001, 32'h0);
    set_cap(1'b1);
    rd(2'd1, d);
    check("R8 rising flag", d, 32'h1);
    rd(2'd3, d);
    check("R8 captured value", d[31:16], 16'h0055);
    wr(2'd1, 4'b0001, 32'h0);
    wr(2'd2, 4'b0011, 32'h0066);
    set_cap(1'b0);
    rd(2'd1, d);
    check("R8 falling ignored flag", d, 32'h0);
    rd(2'd3, d);
    check("R8 falling ignored value", d[31:16], 16'h0055);
    wr(2'd0, 4'b0001, 32'h03);
    set_cap(1'b1);
    rd(2'd1, d);
    check("R8 rising ignored", d, 32'h0);
    set_cap(1'b0);
    rd(2'd3, d);
    check("R8 falling capture", d[31:16], 16'h0066);
    wr(2'd3, 4'b1100, 32'h1234_0000);
    rd(2'd3, d);
    check("R8 capture read-only", d[31:16], 16'h0066);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    wr(2'd1, 4'b0001, 32'hF);
    rd(2'd1, d);
    check("R9 write one keeps", d, 32'h1);
    wr(2'd1, 4'b0001, 32'h0);
    rd(2'd1, d);
    check("R9 write zero clears", d, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(2'd0, 4'b0001, 32'h3);
    wr(2'd2, 4'b0011, 32'hFFFF);
    @(negedge clk) ext_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd1; bus_be = 4'b0001; bus_wdata = 32'h0; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_be = '0;
    repeat (3) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd1, d);
    check("R10 set beats clear", d, 32'h8);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    #1;
    check("R11 disabled no irq", {31'b0, irq}, 0);
    check("R12 idle class", {30'b0, vec_class}, 0);
    wr(2'd0, 4'b0011, 32'h0813);
    #1;
    check("R11 overflow irq", {31'b0, irq}, 1);
    check("R12 overflow class", {30'b0, vec_class}, 3);
    wr(2'd0, 4'b0011, 32'h0F13);
    set_cap(1'b1);
    #1;
    check("R12 capture wins", {30'b0, vec_class}, 1);
    wr(2'd1, 4'b0001, 32'hE);
    wr(2'd2, 4'b0011, 32'h0012);
    step(1);
    rd(2'd1, d);
    check("R4 second match", d, 32'hA);
    check("R12 compare over overflow", {30'b0, vec_class}, 2);
    wr(2'd0, 4'b0011, 32'h0013);
    #1;
    check("R11 all disabled", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_ext_and_load;
    t_cmp_a;
    t_clear_a;
    t_cmp_b;
    t_ovf;
    t_capture;
    t_sticky;
    t_race;
    t_irq;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule